// File: doc/BRIEF.md
# Bit-Serial Handshake Boot Loader

This block decides at reset whether the system boots normally or loads a program over a four-wire serial handshake. It samples a test pin while reset is held. A high level selects normal boot. The block then sits idle with its handshake lines low and raises a normal-boot flag. A low level selects transfer mode, in which the block acts as the slave of an external master. It receives a fixed number of bytes one bit at a time, writes each byte through a simple memory write port, and finally raises an execute request that carries the load address.

The master sees the slave's progress through two handshake lines, A and B. Each pair is written below as {A,B}. The strobe and data inputs pass through a multi-stage synchronizer before the controller sees them.

In transfer mode the controller first waits for the strobe to read high. It then waits for the data line to fall from 1 to 0. After that it acknowledges the synchronisation and clocks in bits, most significant bit first. Every strobe-high wait is qualified by a strobe-low sighting first, so that one long strobe-high phase can never be counted twice.

Top module: `serial_boot_loader`

## Requirements
- R1: When the test pin is high during reset, the block enters normal boot. It drives boot_normal_o=1 and {A,B}=00, never writes memory, never raises exec_go_o, and ignores strobe and data.
- R2: When the test pin is low during reset, the block drives {A,B}=00. It waits for the synchronized strobe to read 1. It then waits for the synchronized data to read 1 and afterwards 0. Data edges seen while the strobe has not yet read high do not start synchronisation.
- R3: Once the data falls, the block drives {A,B}=10. It holds that value until the synchronized strobe reads 0.
- R4: For each bit, the block drives {A,B}=11, waits for strobe low (for the first bit of the transfer, the low seen during R3 serves), then waits for strobe high. At that high it samples data as the next bit, most significant bit first.
- R5: On the edge where the eighth bit of a byte is sampled, the block does two things at once. It issues a write pulse exactly one cycle long, carrying the address LOAD_BASE plus the byte index and the assembled byte. In that same cycle it switches {A,B} to 01.
- R6: The block holds {A,B}=01 until the strobe is seen low and then high. It then returns to {A,B}=11 for the next byte.
- R7: Exactly BYTE_COUNT writes are made, to consecutive addresses from 0xA880. After the last byte-acknowledge, exec_go_o rises with exec_addr_o=0xA880 and {A,B}=00.
- R8: A strobe-high phase of any length yields one bit. Data changes after that bit has been sampled, while the strobe is still high, do not alter stored bytes.
- R9: Reset asserted in the middle of a transfer discards partial progress. The test pin is sampled again, and a new transfer writes from 0xA880.
- R10: After completion, exec_go_o stays high and further strobe or data activity produces no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; test_i sampled while high |
| test_i | input | 1 | Boot select: 1 normal boot, 0 transfer mode |
| strobe_i | input | 1 | Master strobe, asynchronous |
| data_i | input | 1 | Master serial data, asynchronous |
| hs_a_o | output | 1 | Handshake line A |
| hs_b_o | output | 1 | Handshake line B |
| mem_we_o | output | 1 | One-cycle memory write strobe |
| mem_addr_o | output | ADDR_W | Write address |
| mem_data_o | output | BITS_PER_BYTE | Write data |
| exec_go_o | output | 1 | Execute request after the whole program arrived |
| exec_addr_o | output | ADDR_W | Execution start address |
| boot_normal_o | output | 1 | Normal boot selected |

## Verification
The memory write of a finished byte and the switch of the handshake lines to the byte-acknowledge pattern happen on the same clock edge. On the following cycle, a fast master may already drive the strobe low for that acknowledge. The bench provokes this with strobe pulses of one-cycle width, mixed with longer ones, on the eighth bit of many bytes. A behavioural reference model predicts the write strobe, address, data and both handshake lines for every cycle. All of them are compared together on each clock, so a write lost or shifted next to a line change is reported.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

  typedef enum logic [3:0] {
    ST_NORMAL,
    ST_ARM,
    ST_SYNC_HI,
    ST_SYNC_LO,
    ST_ACK,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_BYTE_LO,
    ST_BYTE_HI,
    ST_DONE
  } sbl_state_t;

  // Handshake pair {A,B} shown to the master in each state
  function automatic logic [1:0] lines_for(sbl_state_t s);
    case (s)
      ST_ACK:                 return 2'b10;
      ST_BIT_LO, ST_BIT_HI:   return 2'b11;
      ST_BYTE_LO, ST_BYTE_HI: return 2'b01;
      default:                return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/sbl_sync.sv
module sbl_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/sbl_assembler.sv
module sbl_assembler #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_i,
  input  logic            bit_i,
  output logic            last_o,
  output logic [BITS-1:0] byte_o
);

  localparam int CNT_W = (BITS > 1) ? $clog2(BITS) : 1;

  logic [BITS-1:0]  shreg;
  logic [CNT_W-1:0] cnt;

  // MSB first: earlier bits move toward the top
  assign byte_o = {shreg[BITS-2:0], bit_i};
  assign last_o = (cnt == CNT_W'(BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (shift_i) begin
      shreg <= byte_o;
      cnt   <= last_o ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sbl_writer.sv
module sbl_writer #(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 8,
  parameter int              IDX_W     = 8,
  parameter logic [ADDR_W-1:0] BASE    = 16'hA880
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      we_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      we_o <= fire_i;
      if (fire_i) begin
        addr_o <= BASE + ADDR_W'(idx_i);
        data_o <= data_i;
      end
    end
  end

endmodule

// File: rtl/sbl_ctrl.sv
module sbl_ctrl
  import sbl_pkg::*;
#(
  parameter int BYTE_COUNT = 256,
  parameter int IDX_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             test_i,
  input  logic             strb_s_i,
  input  logic             data_s_i,
  input  logic             last_bit_i,
  output logic             shift_o,
  output logic             fire_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             hs_a_o,
  output logic             hs_b_o,
  output logic             done_o,
  output logic             normal_o
);

  sbl_state_t state, nxt;
  logic       last_byte;

  assign last_byte = (idx_o == IDX_W'(BYTE_COUNT - 1));
  assign shift_o   = (state == ST_BIT_HI) && strb_s_i;
  assign fire_o    = shift_o && last_bit_i;

  always_comb begin
    nxt = state;
    case (state)
      ST_ARM:     if (strb_s_i)  nxt = ST_SYNC_HI;
      ST_SYNC_HI: if (data_s_i)  nxt = ST_SYNC_LO;
      ST_SYNC_LO: if (!data_s_i) nxt = ST_ACK;
      ST_ACK:     if (!strb_s_i) nxt = ST_BIT_HI;
      ST_BIT_LO:  if (!strb_s_i) nxt = ST_BIT_HI;
      ST_BIT_HI:  if (strb_s_i)  nxt = last_bit_i ? ST_BYTE_LO : ST_BIT_LO;
      ST_BYTE_LO: if (!strb_s_i) nxt = ST_BYTE_HI;
      ST_BYTE_HI: if (strb_s_i)  nxt = last_byte ? ST_DONE : ST_BIT_LO;
      default:                   nxt = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= test_i ? ST_NORMAL : ST_ARM;
      idx_o    <= '0;
      hs_a_o   <= 1'b0;
      hs_b_o   <= 1'b0;
      done_o   <= 1'b0;
      normal_o <= test_i;
    end else begin
      state            <= nxt;
      {hs_a_o, hs_b_o} <= lines_for(nxt);
      done_o           <= (nxt == ST_DONE);
      normal_o         <= (nxt == ST_NORMAL);
      if (state == ST_BYTE_HI && strb_s_i)
        idx_o <= idx_o + 1'b1;
    end
  end

endmodule

// File: rtl/serial_boot_loader.sv
module serial_boot_loader #(
  parameter int                BYTE_COUNT    = 256,
  parameter int                BITS_PER_BYTE = 8,
  parameter int                ADDR_W        = 16,
  parameter logic [ADDR_W-1:0] LOAD_BASE     = 16'hA880,
  parameter int                SYNC_STAGES   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     test_i,
  input  logic                     strobe_i,
  input  logic                     data_i,
  output logic                     hs_a_o,
  output logic                     hs_b_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  output logic [BITS_PER_BYTE-1:0] mem_data_o,
  output logic                     exec_go_o,
  output logic [ADDR_W-1:0]        exec_addr_o,
  output logic                     boot_normal_o
);

  localparam int IDX_W = (BYTE_COUNT > 1) ? $clog2(BYTE_COUNT) : 1;

  logic [1:0]               sync_q;
  logic                     strb_s, data_s;
  logic                     shift, fire, last_bit;
  logic [IDX_W-1:0]         idx;
  logic [BITS_PER_BYTE-1:0] byte_val;

  sbl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({strobe_i, data_i}),
    .q_o (sync_q)
  );

  assign strb_s = sync_q[1];
  assign data_s = sync_q[0];

  sbl_ctrl #(.BYTE_COUNT(BYTE_COUNT), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .test_i     (test_i),
    .strb_s_i   (strb_s),
    .data_s_i   (data_s),
    .last_bit_i (last_bit),
    .shift_o    (shift),
    .fire_o     (fire),
    .idx_o      (idx),
    .hs_a_o     (hs_a_o),
    .hs_b_o     (hs_b_o),
    .done_o     (exec_go_o),
    .normal_o   (boot_normal_o)
  );

  sbl_assembler #(.BITS(BITS_PER_BYTE)) u_asm (
    .clk     (clk),
    .rst     (rst),
    .shift_i (shift),
    .bit_i   (data_s),
    .last_o  (last_bit),
    .byte_o  (byte_val)
  );

  sbl_writer #(
    .ADDR_W (ADDR_W),
    .DATA_W (BITS_PER_BYTE),
    .IDX_W  (IDX_W),
    .BASE   (LOAD_BASE)
  ) u_wr (
    .clk    (clk),
    .rst    (rst),
    .fire_i (fire),
    .idx_i  (idx),
    .data_i (byte_val),
    .we_o   (mem_we_o),
    .addr_o (mem_addr_o),
    .data_o (mem_data_o)
  );

  assign exec_addr_o = LOAD_BASE;

endmodule

// File: rtl/sbl_checker.sv
module sbl_checker #(
  parameter int                BYTE_COUNT = 256,
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] LOAD_BASE  = 16'hA880
) (
  input logic              clk,
  input logic              rst,
  input logic              hs_a_o,
  input logic              hs_b_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              exec_go_o,
  input logic              boot_normal_o
);

  localparam int CW = $clog2(BYTE_COUNT + 1) + 1;

  logic [CW-1:0]     wr_cnt;
  logic [ADDR_W-1:0] exp_addr;

  always_ff @(posedge clk) begin
    if (rst)           wr_cnt <= '0;
    else if (mem_we_o) wr_cnt <= wr_cnt + 1'b1;
  end

  assign exp_addr = LOAD_BASE + ADDR_W'(wr_cnt);

  AST_NORMAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    boot_normal_o |-> (!mem_we_o && !hs_a_o && !hs_b_o && !exec_go_o)); // R1
  AST_WRITE_LINES: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (!hs_a_o && hs_b_o)); // R5
  AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |=> !mem_we_o); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (mem_addr_o == exp_addr)); // R7
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (rst)
    $rose(exec_go_o) |-> (wr_cnt == CW'(BYTE_COUNT))); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    exec_go_o |=> (exec_go_o && !mem_we_o)); // R10

endmodule

bind serial_boot_loader sbl_checker #(
  .BYTE_COUNT (BYTE_COUNT),
  .ADDR_W     (ADDR_W),
  .LOAD_BASE  (LOAD_BASE)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .hs_a_o        (hs_a_o),
  .hs_b_o        (hs_b_o),
  .mem_we_o      (mem_we_o),
  .mem_addr_o    (mem_addr_o),
  .exec_go_o     (exec_go_o),
  .boot_normal_o (boot_normal_o)
);

// File: tb/sim_serial_boot_loader.sv
`timescale 1ns/1ps
module sim_serial_boot_loader;

  logic        clk = 0;
  logic        rst = 1, test = 1, strobe = 0, data = 0;
  logic        hs_a_o, hs_b_o, mem_we_o, exec_go_o, boot_normal_o;
  logic [15:0] mem_addr_o, exec_addr_o;
  logic [7:0]  mem_data_o;

  int n_chk = 0, n_fail = 0, n_writes = 0;
  logic [15:0] last_addr = 0;
  logic [7:0]  got [256];

  always #5 clk = ~clk;

  serial_boot_loader u0 (
    .clk(clk), .rst(rst), .test_i(test), .strobe_i(strobe), .data_i(data),
    .hs_a_o(hs_a_o), .hs_b_o(hs_b_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
    .exec_go_o(exec_go_o), .exec_addr_o(exec_addr_o),
    .boot_normal_o(boot_normal_o)
  );

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: phases 0 normal,1 arm,2 wait data 1,3 wait data 0,
  // 4 ack,5 bit low,6 bit high,7 byte-ack low,8 byte-ack high,9 done
  int  m_ph = 0, m_bits = 0, m_bytes = 0, m_sh = 0;
  bit  m_s1, m_s2, m_d1, m_d2, m_live = 0;
  bit  exp_we = 0;
  int  exp_addr = 0, exp_data = 0;

  always @(posedge clk) begin
    bit s, d;
    if (rst) begin
      m_ph = test ? 0 : 1;
      m_bits = 0; m_bytes = 0; m_sh = 0; exp_we = 0;
      m_s1 = 0; m_s2 = 0; m_d1 = 0; m_d2 = 0; m_live = 1;
    end else begin
      s = m_s2; d = m_d2; exp_we = 0;
      case (m_ph)
        1: if (s)  m_ph = 2;
        2: if (d)  m_ph = 3;
        3: if (!d) m_ph = 4;
        4: if (!s) m_ph = 6;
        5: if (!s) m_ph = 6;
        6: if (s) begin
             m_sh = ((m_sh << 1) | int'(d)) & 8'hFF;
             m_bits++;
             if (m_bits == 8) begin
               exp_we = 1; exp_addr = 16'hA880 + m_bytes; exp_data = m_sh;
               m_bits = 0; m_ph = 7;
             end else m_ph = 5;
           end
        7: if (!s) m_ph = 8;
        8: if (s) begin
             m_bytes++;
             m_ph = (m_bytes == 256) ? 9 : 5;
           end
        default: ;
      endcase
      m_s2 = m_s1; m_s1 = strobe; m_d2 = m_d1; m_d1 = data;
    end
  end

  function automatic int exp_lines(int p);
    if (p == 4) return 2;
    if (p == 5 || p == 6) return 3;
    if (p == 7 || p == 8) return 1;
    return 0;
  endfunction

  function automatic string ph_tag(int p);
    if (p == 0) return "R1";
    if (p <= 3) return "R2";
    if (p == 4) return "R3";
    if (p <= 6) return "R4";
    if (p <= 8) return "R6";
    return "R7";
  endfunction

  always @(negedge clk) begin
    if (m_live && !rst) begin
      chk(ph_tag(m_ph), {hs_a_o, hs_b_o}, exp_lines(m_ph), "handshake lines");
      chk("R5", mem_we_o, exp_we, "write strobe");
      if (exp_we) begin
        chk("R5", mem_addr_o, exp_addr, "write address");
        chk("R5", mem_data_o, exp_data, "write data");
      end
      chk(ph_tag(m_ph), exec_go_o, m_ph == 9, "exec request");
      chk(ph_tag(m_ph), boot_normal_o, m_ph == 0, "normal flag");
      if (mem_we_o) begin
        n_writes++;
        last_addr = mem_addr_o;
        if (mem_addr_o - 16'hA880 < 256) got[mem_addr_o - 16'hA880] = mem_data_o;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit b, input int lo, input int hi);
    @(negedge clk); strobe = 0; data = b;
    step(lo - 1);
    @(negedge clk); strobe = 1;
    step(hi - 1);
  endtask

  // R8: one long strobe-high phase, data flipped after the sample point
  task automatic pulse_long(input bit b);
    @(negedge clk); strobe = 0; data = b;
    step(2);
    strobe = 1; step(4);
    data = ~b; step(17);
  endtask

  function automatic logic [7:0] bval(input int k);
    return 8'((k * 29 + 7) ^ (k >> 3));
  endfunction

  task automatic send_byte(input int k);
    logic [7:0] v = bval(k);
    for (int b = 7; b >= 0; b--) begin
      if (k == 100 && b == 3) pulse_long(v[b]);
      else pulse(v[b], 1 + ((k + b) % 3), 1 + ((k * 3 + b) % 4));
    end
    pulse(~v[0], 1 + (k % 2), 1 + (k % 3));
  endtask

  task automatic do_sync();
    @(negedge clk); strobe = 1; data = 1;
    step(5);
    data = 0; step(6);
  endtask

  task automatic do_reset(input bit t);
    @(negedge clk); rst = 1; test = t; strobe = 0; data = 0;
    step(3);
    rst = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_900_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int w0;
    // R1: normal boot ignores activity
    do_reset(1);
    for (int k = 0; k < 6; k++) pulse(k[0], 2, 2);
    step(3);
    chk("R1", boot_normal_o, 1, "normal flag");
    chk("R1", n_writes, 0, "writes in normal boot");

    // R2: data edges while strobe low do not synchronise
    do_reset(0);
    for (int k = 0; k < 4; k++) begin data = k[0]; step(3); end
    chk("R2", {hs_a_o, hs_b_o}, 0, "lines before sync");
    do_sync();
    chk("R3", {hs_a_o, hs_b_o}, 2, "sync acknowledge");
    for (int k = 0; k < 256; k++) send_byte(k);
    step(6);
    chk("R7", exec_go_o, 1, "exec after last byte");
    chk("R7", n_writes, 256, "write count");
    chk("R7", exec_addr_o, 16'hA880, "exec address");
    for (int k = 0; k < 256; k++) chk("R4 R8", got[k], bval(k), "stored byte");
    for (int k = 0; k < 5; k++) pulse(k[0], 1, 2);
    step(4);
    chk("R10", exec_go_o, 1, "exec held");
    chk("R10", n_writes, 256, "no writes after done");

    // R9: reset in mid transfer restarts cleanly
    do_reset(0);
    step(1);
    chk("R9", {hs_a_o, hs_b_o}, 0, "lines after reset");
    chk("R9", exec_go_o, 0, "exec cleared");
    do_sync();
    send_byte(5); send_byte(6);
    pulse(1, 2, 2); pulse(0, 2, 2); pulse(1, 2, 2);
    do_reset(0);
    do_sync();
    w0 = n_writes;
    send_byte(9);
    step(3);
    chk("R9", n_writes - w0, 1, "write after restart");
    chk("R9", last_addr, 16'hA880, "restart address");

    do_reset(1);
    step(3);
    chk("R1", boot_normal_o, 1, "normal after reselect");
    finish_run();
  end

endmodule